// File: doc/BRIEF.md
# JTAG Debug Mailbox Bridge

This block is a mailbox through which a host debugger, reaching the chip over a JTAG port, and a debug monitor running on the on-chip processor swap 32-bit words. It keeps one inbound word (host to monitor), one outbound word (monitor to host) and an 8-bit control word carrying two full-flags and a stay-awake bit. The processor reaches these through a simple word-addressed load/store port: word 0 (byte offset 0x0) is inbound data, word 1 (0x4) is outbound data, word 2 (0x8) is control, and word 3 reads as zero.

On the JTAG side an existing TAP controller supplies TCK, TDI, capture, shift and update strobes and a decoded select code. The block offers five scan paths between TDI and TDO: the two data words, the control byte, and two one-bit virtual paths for the flags. All scan paths shift least significant bit first; TDO shows bit 0 of the shift register. Writes made from the TCK side become events that cross to the system clock through a toggle request, a two-flop synchronizer and a toggle acknowledge returned the same way.

The two flags follow asymmetric rules so that neither side can undo the other's handshake: a 0 written from JTAG leaves either flag alone, a 1 clears the outbound flag (word taken) or sets the inbound flag and pulses the interrupt (word delivered).

Top module: `jtag_mailbox`

## Requirements
- R1: After reset ofull and ifull are 0, the stay-awake bit is 1 (control reads 0x04), both data words read 0 and irq is low.
- R2: Bus writes at word 0 and word 1 load the inbound and outbound words, which read back unchanged; word 3 reads as zero.
- R3: A bus write to word 2 sets ofull when bit 0 is 1 and leaves it otherwise, clears ifull when bit 1 is 0 and leaves it otherwise, and loads the stay-awake bit from bit 2; control reads {bits 7:3 zero, stay-awake at bit 2, ifull at bit 1, ofull at bit 0}, upper 24 bits zero.
- R4: Select code 1 captures the inbound word into a 32-bit scan path, and the update writes the shifted-in word into the inbound register.
- R5: Select code 2 captures the outbound word; its update has no effect on the outbound register.
- R6: Select code 5 is a 1-bit path that captures ofull; updating with 1 clears ofull, updating with 0 leaves it.
- R7: Select code 4 is a 1-bit path that captures ifull; updating with 1 sets ifull and raises irq, updating with 0 changes nothing and raises no irq.
- R8: Select code 3 is an 8-bit path that captures the control byte; on update bit 0 = 1 clears ofull, bit 1 = 1 sets ifull and raises irq, bit 2 loads the stay-awake bit.
- R9: An update arriving before the previous JTAG event has been acknowledged back in the TCK domain is dropped.
- R10: irq is a single system-clock-cycle pulse for each JTAG write of 1 to ifull.
- R11: With any other select code (0, 6, 7) TDO is held at 0 and an update changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System-domain asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Word index: 0 inbound, 1 outbound, 2 control |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed word |
| irq | output | 1 | One-cycle pulse when the host delivers a word |
| stay_awake | output | 1 | Keeps the block out of peripheral power-down |
| tck | input | 1 | Test clock |
| trst_n | input | 1 | TCK-domain asynchronous reset, active low |
| tdi | input | 1 | Serial scan input |
| cap | input | 1 | Capture strobe from the TAP |
| shf | input | 1 | Shift strobe from the TAP |
| upd | input | 1 | Update strobe from the TAP |
| sel | input | 3 | Decoded scan path select |
| tdo | output | 1 | Serial scan output |

## Verification
The control word is swept over all eight low-bit combinations from the bus, and over all eight from the control scan path starting from a known flag state, so each bit's set, clear and hold rule is told apart from its neighbours and from the opposite flag. Each one-bit flag path is driven with both 0 and 1, separating the hold case from the clear or set-plus-interrupt case. Data paths are scanned with words whose captured and shifted-in values differ, which shows that capture samples the register and that only the inbound update writes. A scan that updates, shifts one bit and updates again two TCK cycles later distinguishes a dropped event from an accepted one.

// File: rtl/jtag_mailbox.sv
module jtag_mailbox #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          stay_awake,
  input  logic          tck,
  input  logic          trst_n,
  input  logic          tdi,
  input  logic          cap,
  input  logic          shf,
  input  logic          upd,
  input  logic [2:0]    sel,
  output logic          tdo
);
  localparam int CW = 8;
  localparam logic [2:0] SEL_IN = 3'd1, SEL_OUT = 3'd2, SEL_CTL = 3'd3,
                         SEL_IFL = 3'd4, SEL_OFL = 3'd5;
  typedef enum logic [1:0] {EV_DIN, EV_IFL, EV_OFL, EV_CTL} ev_t;

  logic [DW-1:0] din_q, dout_q;
  logic ofull_q, ifull_q, sleep_q;
  logic [CW-1:0] ctrl_rd;
  assign ctrl_rd = {5'b0, sleep_q, ifull_q, ofull_q};

  // TCK domain
  logic [DW-1:0] sr, ev_data;
  ev_t ev_kind, want_kind;
  logic req_t, ack_s1, ack_s2, ack_t, want, busy, sel_ok;

  assign sel_ok = sel inside {SEL_IN, SEL_OUT, SEL_CTL, SEL_IFL, SEL_OFL};
  assign tdo    = sel_ok & sr[0];
  assign busy   = req_t ^ ack_s2;

  always_comb begin
    want = 1'b0;
    want_kind = EV_DIN;
    if (upd) begin
      case (sel)
        SEL_IN:  want = 1'b1;
        SEL_CTL: begin want = 1'b1; want_kind = EV_CTL; end
        SEL_IFL: begin want = sr[0]; want_kind = EV_IFL; end
        SEL_OFL: begin want = sr[0]; want_kind = EV_OFL; end
        default: want = 1'b0;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= '0; ev_data <= '0; ev_kind <= EV_DIN;
      req_t <= 1'b0; ack_s1 <= 1'b0; ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_t;
      ack_s2 <= ack_s1;
      if (cap) begin
        case (sel)
          SEL_IN:  sr <= din_q;
          SEL_OUT: sr <= dout_q;
          SEL_CTL: sr <= {{(DW-CW){1'b0}}, ctrl_rd};
          SEL_IFL: sr <= {{(DW-1){1'b0}}, ifull_q};
          SEL_OFL: sr <= {{(DW-1){1'b0}}, ofull_q};
          default: sr <= '0;
        endcase
      end else if (shf) begin
        case (sel)
          SEL_IN, SEL_OUT:  sr <= {tdi, sr[DW-1:1]};
          SEL_CTL:          sr <= {{(DW-CW){1'b0}}, tdi, sr[CW-1:1]};
          SEL_IFL, SEL_OFL: sr <= {{(DW-1){1'b0}}, tdi};
          default:          sr <= sr;
        endcase
      end
      if (want && !busy) begin
        ev_data <= sr;
        ev_kind <= want_kind;
        req_t   <= ~req_t;
      end
    end
  end

  // System domain
  logic req_s1, req_s2, req_s3, ev, bus_ctl, bus_set_of;
  assign ack_t      = req_s3;
  assign ev         = req_s2 ^ req_s3;
  assign bus_ctl    = bus_we && bus_addr == 2'd2;
  assign bus_set_of = bus_ctl && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= '0; dout_q <= '0;
      ofull_q <= 1'b0; ifull_q <= 1'b0; sleep_q <= 1'b1; irq <= 1'b0;
      req_s1 <= 1'b0; req_s2 <= 1'b0; req_s3 <= 1'b0;
    end else begin
      req_s1 <= req_t;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
      irq <= ev && (ev_kind == EV_IFL || (ev_kind == EV_CTL && ev_data[1]));
      if (bus_we) begin
        case (bus_addr)
          2'd0: din_q  <= bus_wdata;
          2'd1: dout_q <= bus_wdata;
          2'd2: begin
            if (bus_wdata[0])  ofull_q <= 1'b1;
            if (!bus_wdata[1]) ifull_q <= 1'b0;
            sleep_q <= bus_wdata[2];
          end
          default: ;
        endcase
      end
      if (ev) begin
        case (ev_kind)
          EV_DIN: din_q   <= ev_data;
          EV_IFL: ifull_q <= 1'b1;
          EV_OFL: if (!bus_set_of) ofull_q <= 1'b0;
          EV_CTL: begin
            if (ev_data[0] && !bus_set_of) ofull_q <= 1'b0;
            if (ev_data[1]) ifull_q <= 1'b1;
            sleep_q <= ev_data[2];
          end
          default: ;
        endcase
      end
    end
  end

  assign stay_awake = sleep_q;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = din_q;
      2'd1:    bus_rdata = dout_q;
      2'd2:    bus_rdata = {{(DW-CW){1'b0}}, ctrl_rd};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module jtag_mailbox_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          irq,
  input logic          ofull,
  input logic          ifull,
  input logic          sleep,
  input logic [DW-1:0] dout
);
  // R1
  rst_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!ofull && !ifull && sleep && !irq));
  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R7
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ifull);
  // R3
  ofull_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd2 && bus_wdata[0]) |=> ofull);
  // R5
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == 2'd1) |=> $stable(dout));
endmodule

bind jtag_mailbox jtag_mailbox_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .ofull(ofull_q), .ifull(ifull_q),
  .sleep(sleep_q), .dout(dout_q)
);

// File: tb/sim_jtag_mailbox.sv
module sim_jtag_mailbox;
  localparam int CLK_P = 10;
  localparam int TCK_P = 100;

  logic clk = 0, tck = 0, rst_n = 0, trst_n = 0;
  logic bus_we = 0, tdi = 0, cap = 0, shf = 0, upd = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [2:0] sel = 0;
  logic irq, stay_awake, tdo;
  int n_run = 0, n_fail = 0, irq_cnt = 0, irq_wide = 0;
  logic irq_prev = 0;

  jtag_mailbox u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .stay_awake(stay_awake),
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .cap(cap), .shf(shf), .upd(upd),
    .sel(sel), .tdo(tdo));

  always #(CLK_P/2) clk = ~clk;
  always #(TCK_P/2) tck = ~tck;

  always @(posedge clk) begin
    if (irq) irq_cnt++;
    if (irq && irq_prev) irq_wide++;
    irq_prev <= irq;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic scan(input logic [2:0] s, input int len, input logic [31:0] din,
                      output logic [31:0] dout);
    dout = 0;
    @(negedge tck); sel = s; cap = 1;
    for (int i = 0; i < len; i++) begin
      @(negedge tck); cap = 0; shf = 1; tdi = din[i]; dout[i] = tdo;
    end
    @(negedge tck); shf = 0; upd = 1;
    @(negedge tck); upd = 0;
    repeat (4) @(negedge tck);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, s;
    logic of, ifl, sl;
    int ic;
    repeat (3) @(negedge tck);
    rst_n = 1; trst_n = 1;
    // R1
    rd(2, r); chk("R1 ctrl", r, 32'h4);
    rd(0, r); chk("R1 din", r, 0);
    rd(1, r); chk("R1 dout", r, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 stay_awake", {31'b0, stay_awake}, 1);
    // R2
    for (int k = 0; k < 3; k++) begin
      wr(0, 32'h1234_5678 * (k + 1)); wr(1, ~(32'h0F0F_3C3C + k));
      rd(0, r); chk("R2 din", r, 32'h1234_5678 * (k + 1));
      rd(1, r); chk("R2 dout", r, ~(32'h0F0F_3C3C + k));
    end
    rd(3, r); chk("R2 word3", r, 0);
    // R3 bus sweep
    of = 0; ifl = 0; sl = 1;
    for (int w = 0; w < 8; w++) begin
      wr(2, 32'hFFFF_FFF8 | w);
      if (w[0]) of = 1;
      if (!w[1]) ifl = 0;
      sl = w[2];
      rd(2, r); chk("R3 ctrl", r, {29'b0, sl, ifl, of});
    end
    // R4
    wr(0, 32'hA5A5_0001);
    scan(1, 32, 32'h3C3C_7E81, r); chk("R4 capture", r, 32'hA5A5_0001);
    rd(0, r); chk("R4 update", r, 32'h3C3C_7E81);
    // R5
    wr(1, 32'hC0DE_0042);
    scan(2, 32, 32'h1111_2222, r); chk("R5 capture", r, 32'hC0DE_0042);
    rd(1, r); chk("R5 unchanged", r, 32'hC0DE_0042);
    // R6
    wr(2, 32'h5);
    scan(5, 1, 0, r); chk("R6 capture", r, 1);
    rd(2, r); chk("R6 write0 holds", r, 32'h5);
    scan(5, 1, 1, r);
    rd(2, r); chk("R6 write1 clears", r, 32'h4);
    scan(5, 1, 0, r); chk("R6 capture cleared", r, 0);
    // R7 / R10
    ic = irq_cnt;
    scan(4, 1, 0, r); chk("R7 capture", r, 0);
    rd(2, r); chk("R7 write0 holds", r, 32'h4);
    chk("R7 no irq", irq_cnt - ic, 0);
    scan(4, 1, 1, r);
    rd(2, r); chk("R7 write1 sets", r, 32'h6);
    chk("R7 irq", irq_cnt - ic, 1);
    scan(4, 1, 0, r); chk("R7 capture set", r, 1);
    chk("R10 width", irq_wide, 0);
    // R8
    for (int v = 0; v < 8; v++) begin
      wr(2, 32'h5);
      ic = irq_cnt;
      scan(3, 8, v, r); chk("R8 capture", r, 32'h5);
      rd(2, r); chk("R8 update", r, {29'b0, v[2], v[1], ~v[0]});
      chk("R8 irq", irq_cnt - ic, v[1]);
    end
    chk("R10 width", irq_wide, 0);
    // R9: update, one shift, update two TCK cycles later
    @(negedge tck); sel = 1; cap = 1;
    for (int i = 0; i < 32; i++) begin
      @(negedge tck); cap = 0; shf = 1; tdi = i[0];
    end
    @(negedge tck); shf = 0; upd = 1;
    @(negedge tck); upd = 0; shf = 1; tdi = 1;
    @(negedge tck); shf = 0; upd = 1;
    @(negedge tck); upd = 0;
    repeat (4) @(negedge tck);
    rd(0, r); chk("R9 second update dropped", r, 32'hAAAA_AAAA);
    // R11
    rd(2, s);
    for (int c = 0; c < 8; c++) begin
      if (c inside {0, 6, 7}) begin
        scan(c[2:0], 8, 32'hFF, r); chk("R11 tdo", r, 0);
        rd(0, r); chk("R11 din", r, 32'hAAAA_AAAA);
        rd(2, r); chk("R11 ctrl", r, s);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule